// File: doc/BRIEF.md
# Configurable sum-of-products logic macrocell

This block is one programmable logic cell driven by a static configuration word. Five product-term inputs arrive already evaluated. Any subset of them is ORed into a sum, optionally together with a cascade input from a neighbouring cell. The cascade output carries that sum on, so a chain of cells can build wide sums. An XOR stage then adjusts the polarity of the sum, or folds in one product term.

One storage element follows the XOR stage. It works as a D, T, JK or SR flip-flop, or as a level-sensitive latch. Its clock, clock enable, asynchronous clear and asynchronous set each come from a global signal or from a chosen product term, and the data input has its own selector. The pin output and the buried feedback each choose, independently, between the registered value and the combinatorial value. The output enable has its own selector.

Every control function picks its product term through a small index field in the configuration word. A product term can therefore drive the sum and a control function at the same time. An index of 5 or more selects constant 0. The cell has no data streams and no handshake: all pins are plain levels.

Top module: `mc_cell`

## Requirements
- R1: `casc_out` is the OR of the product terms whose `sum_mask` bit is set, ORed with `casc_in` when `casc_en` is 1.
- R2: The combinatorial value is the sum XOR a second operand. That operand is 0 for `xor_sel`=0, 1 for `xor_sel`=1 and `pt[xor_pt]` for `xor_sel`=2.
- R3: The register data input is the combinatorial value for `d_sel`=0, `pt[d_pt]` for `d_sel`=1 and `pin_in` for `d_sel`=2.
- R4: With `mode`=0 (D) the register loads the data input on the rising edge of the selected clock. With `mode`=1 (T) it inverts when the data input is 1 and holds when it is 0.
- R5: With `mode`=2 (JK), J=`pt[d_pt]` and K=`pt[k_pt]`: 10 sets the register, 01 clears it, 11 toggles it and 00 holds it. With `mode`=3 (SR), S=`pt[d_pt]` and R=`pt[k_pt]`: 10 sets the register, 01 clears it, and 11 or 00 hold it.
- R6: With `mode`=4 (latch) the stored value follows the data input while the selected clock is high and holds it while the clock is low.
- R7: `clk_pt_en`=0 selects `gclk` as the clock. `clk_pt_en`=1 selects `pt[clk_pt]`, and `gclk` edges then have no effect.
- R8: With `clk_pt_en`=0 and `ce_en`=1, a clock edge is ignored while `pt[ce_pt]` is 0. With `clk_pt_en`=1 the clock enable has no effect.
- R9: `ar_sel` picks the asynchronous clear: 0 off, 1 `gclr`, 2 `pt[ar_pt]`, 3 the OR of both. `ap_en`=1 makes `pt[ap_pt]` an asynchronous set. A clear overrides a set and forces 0. A low `rst_n` also clears.
- R10: `pin_out` is the register value when `out_reg`=1 and the combinatorial value otherwise. `fb_out` makes the same choice from `fb_reg`, independently of `out_reg`.
- R11: `pin_oe` is 1 for `oe_sel`=0, 0 for `oe_sel`=1, `goe[0]` for 2, `goe[1]` for 3 and `pt[oe_pt]` for 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock |
| rst_n | input | 1 | Active-low asynchronous power-up clear |
| cfg | input | CFG_W | Static configuration word (packed `mc_cfg_t`) |
| pt | input | 5 | Evaluated product terms |
| casc_in | input | 1 | Cascade sum from the neighbouring cell |
| pin_in | input | 1 | Pin input value for the direct data path |
| gclr | input | 1 | Global asynchronous clear |
| goe | input | 2 | Two global output-enable signals |
| casc_out | output | 1 | Cascade sum passed to the next cell |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Buried feedback value |

## Verification
A clear and a set can be active at the same moment. The bench raises the set term on its own, then raises the clear term on top of it, and expects 0. It then drops the clear alone and expects 1 at once. A second collision is a clock edge that meets a low clock enable, or that meets S and R both high in SR mode. In both cases the bench applies the edge and expects the register value from before the edge.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int NPT = 5;
  localparam int IW  = $clog2(NPT + 1);

  typedef enum logic [1:0] {XS_ZERO = 2'd0, XS_ONE = 2'd1, XS_PT = 2'd2} mc_xsel_e;
  typedef enum logic [1:0] {DS_XOR = 2'd0, DS_PT = 2'd1, DS_PIN = 2'd2} mc_dsel_e;
  typedef enum logic [2:0] {
    MD_D = 3'd0, MD_T = 3'd1, MD_JK = 3'd2, MD_SR = 3'd3, MD_LATCH = 3'd4
  } mc_mode_e;
  typedef enum logic [1:0] {AR_OFF = 2'd0, AR_GLB = 2'd1, AR_PT = 2'd2, AR_BOTH = 2'd3} mc_arsel_e;
  typedef enum logic [2:0] {
    OE_ON = 3'd0, OE_OFF = 3'd1, OE_G0 = 3'd2, OE_G1 = 3'd3, OE_PT = 3'd4
  } mc_oesel_e;

  typedef struct packed {
    logic [NPT-1:0] sum_mask;
    logic           casc_en;
    mc_xsel_e       xor_sel;
    logic [IW-1:0]  xor_pt;
    mc_dsel_e       d_sel;
    logic [IW-1:0]  d_pt;
    logic [IW-1:0]  k_pt;
    mc_mode_e       mode;
    logic           clk_pt_en;
    logic [IW-1:0]  clk_pt;
    logic           ce_en;
    logic [IW-1:0]  ce_pt;
    mc_arsel_e      ar_sel;
    logic [IW-1:0]  ar_pt;
    logic           ap_en;
    logic [IW-1:0]  ap_pt;
    logic           out_reg;
    logic           fb_reg;
    mc_oesel_e      oe_sel;
    logic [IW-1:0]  oe_pt;
  } mc_cfg_t;

  localparam int CFG_W = $bits(mc_cfg_t);
endpackage

// File: rtl/mc_sum.sv
module mc_sum
  import mc_pkg::*;
#(
  parameter int N = NPT
) (
  input  logic         gclk,
  input  logic         rst_n,
  input  logic [N-1:0] pt,
  input  logic [N-1:0] mask,
  input  logic         casc_en,
  input  logic         casc_in,
  input  mc_xsel_e     xor_sel,
  input  logic         xor_pt_val,
  output logic         casc_out,
  output logic         comb
);
  logic [N-1:0] gated;
  logic         xor_op;

  generate
    for (genvar g = 0; g < N; g++) begin : g_gate
      assign gated[g] = pt[g] & mask[g];
    end
  endgenerate

  assign casc_out = (|gated) | (casc_en & casc_in);

  always_comb begin
    case (xor_sel)
      XS_ONE:  xor_op = 1'b1;
      XS_PT:   xor_op = xor_pt_val;
      default: xor_op = 1'b0;
    endcase
  end

  assign comb = casc_out ^ xor_op;

  assert_casc_pass_R1: assert property (@(posedge gclk) disable iff (!rst_n)
    (casc_en && casc_in) |-> casc_out);
  assert_empty_sum_R1: assert property (@(posedge gclk) disable iff (!rst_n)
    ((mask == '0) && !(casc_en && casc_in)) |-> !casc_out);
  assert_polarity_R2: assert property (@(posedge gclk) disable iff (!rst_n)
    (xor_sel == XS_ONE) |-> (comb != casc_out));
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic      gclk,
  input  logic      rst_n,
  input  mc_mode_e  mode,
  input  logic      clk_pt_en,
  input  logic      clk_pt_val,
  input  logic      ce_en,
  input  logic      ce_val,
  input  logic      d_val,
  input  logic      j_val,
  input  logic      k_val,
  input  mc_arsel_e ar_sel,
  input  logic      ar_pt_val,
  input  logic      gclr,
  input  logic      ap_en,
  input  logic      ap_val,
  output logic      q
);
  logic clk_eff, ce_ok, clr_a, set_a, nxt, ff, lat;

  assign clk_eff = clk_pt_en ? clk_pt_val : gclk;
  assign ce_ok   = clk_pt_en | ~ce_en | ce_val;
  assign clr_a   = ~rst_n | (ar_sel[0] & gclr) | (ar_sel[1] & ar_pt_val);
  // set is masked by clear so that releasing the clear re-triggers the set
  assign set_a   = ap_en & ap_val & ~clr_a;

  always_comb begin
    case (mode)
      MD_T:    nxt = ff ^ d_val;
      MD_JK:   nxt = (j_val & ~ff) | (~k_val & ff);
      MD_SR:   nxt = (j_val & ~k_val) | (ff & ~(k_val & ~j_val));
      default: nxt = d_val;
    endcase
  end

  always_ff @(posedge clk_eff or posedge clr_a or posedge set_a) begin
    if (clr_a)      ff <= 1'b0;
    else if (set_a) ff <= 1'b1;
    else if (ce_ok) ff <= nxt;
  end

  always_latch begin
    if (clr_a)        lat <= 1'b0;
    else if (set_a)   lat <= 1'b1;
    else if (clk_eff) lat <= d_val;
  end

  assign q = (mode == MD_LATCH) ? lat : ff;

  assert_clear_wins_R9: assert property (@(posedge gclk) disable iff (!rst_n)
    clr_a |-> (q == 1'b0));
  assert_set_drives_R9: assert property (@(posedge gclk) disable iff (!rst_n)
    set_a |-> (q == 1'b1));
  assert_ce_hold_R8: assert property (@(posedge gclk) disable iff (!rst_n)
    ($past(!clk_pt_en && ce_en && !ce_val && !clr_a && !set_a) && !clr_a && !set_a)
      |-> (ff == $past(ff)));
  assert_sr_hold_R5: assert property (@(posedge gclk) disable iff (!rst_n)
    ($past(!clk_pt_en && mode == MD_SR && j_val && k_val && !clr_a && !set_a)
      && !clr_a && !set_a) |-> (ff == $past(ff)));
endmodule

// File: rtl/mc_outsel.sv
module mc_outsel
  import mc_pkg::*;
(
  input  logic       gclk,
  input  logic       rst_n,
  input  logic       q,
  input  logic       comb,
  input  logic       out_reg,
  input  logic       fb_reg,
  input  mc_oesel_e  oe_sel,
  input  logic [1:0] goe,
  input  logic       oe_pt_val,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_out
);
  assign pin_out = out_reg ? q : comb;
  assign fb_out  = fb_reg ? q : comb;

  always_comb begin
    case (oe_sel)
      OE_ON:   pin_oe = 1'b1;
      OE_G0:   pin_oe = goe[0];
      OE_G1:   pin_oe = goe[1];
      OE_PT:   pin_oe = oe_pt_val;
      default: pin_oe = 1'b0;
    endcase
  end

  assert_same_src_R10: assert property (@(posedge gclk) disable iff (!rst_n)
    (out_reg == fb_reg) |-> (pin_out == fb_out));
  assert_oe_off_R11: assert property (@(posedge gclk) disable iff (!rst_n)
    (oe_sel == OE_OFF) |-> !pin_oe);
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
(
  input  logic             gclk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic [NPT-1:0]   pt,
  input  logic             casc_in,
  input  logic             pin_in,
  input  logic             gclr,
  input  logic [1:0]       goe,
  output logic             casc_out,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out
);
  mc_cfg_t c;
  logic    comb, d_val, q;

  assign c = mc_cfg_t'(cfg);

  function automatic logic pick(input logic [NPT-1:0] v, input logic [IW-1:0] idx);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NPT; k++) begin
      if (idx == IW'(k)) r = v[k];
    end
    return r;
  endfunction

  always_comb begin
    case (c.d_sel)
      DS_PT:   d_val = pick(pt, c.d_pt);
      DS_PIN:  d_val = pin_in;
      default: d_val = comb;
    endcase
  end

  mc_sum #(.N(NPT)) u_sum (
    .gclk      (gclk),
    .rst_n     (rst_n),
    .pt        (pt),
    .mask      (c.sum_mask),
    .casc_en   (c.casc_en),
    .casc_in   (casc_in),
    .xor_sel   (c.xor_sel),
    .xor_pt_val(pick(pt, c.xor_pt)),
    .casc_out  (casc_out),
    .comb      (comb)
  );

  mc_store u_store (
    .gclk      (gclk),
    .rst_n     (rst_n),
    .mode      (c.mode),
    .clk_pt_en (c.clk_pt_en),
    .clk_pt_val(pick(pt, c.clk_pt)),
    .ce_en     (c.ce_en),
    .ce_val    (pick(pt, c.ce_pt)),
    .d_val     (d_val),
    .j_val     (pick(pt, c.d_pt)),
    .k_val     (pick(pt, c.k_pt)),
    .ar_sel    (c.ar_sel),
    .ar_pt_val (pick(pt, c.ar_pt)),
    .gclr      (gclr),
    .ap_en     (c.ap_en),
    .ap_val    (pick(pt, c.ap_pt)),
    .q         (q)
  );

  mc_outsel u_out (
    .gclk     (gclk),
    .rst_n    (rst_n),
    .q        (q),
    .comb     (comb),
    .out_reg  (c.out_reg),
    .fb_reg   (c.fb_reg),
    .oe_sel   (c.oe_sel),
    .goe      (goe),
    .oe_pt_val(pick(pt, c.oe_pt)),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb_out   (fb_out)
  );
endmodule

// File: tb/mc_cell_tb.sv
module mc_cell_tb;
  import mc_pkg::*;

  logic           gclk = 1'b0;
  logic           rst_n;
  mc_cfg_t        c;
  logic [NPT-1:0] pt;
  logic           casc_in, pin_in, gclr;
  logic [1:0]     goe;
  logic           casc_out, pin_out, pin_oe, fb_out;
  int             n_chk = 0, n_bad = 0;
  logic           qm, dm, jm, km, sm, em, om;

  always #10 gclk = ~gclk;

  mc_cell u_dut (
    .gclk(gclk), .rst_n(rst_n), .cfg(c), .pt(pt), .casc_in(casc_in),
    .pin_in(pin_in), .gclr(gclr), .goe(goe), .casc_out(casc_out),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edge_wait();
    @(posedge gclk); #1;
  endtask

  task automatic base_cfg();
    c = '0;
    c.ce_pt = 3'd4;
  endtask

  task automatic do_reset();
    @(negedge gclk); rst_n = 1'b0; #2; rst_n = 1'b1; #1;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    base_cfg();
    pt = '0; casc_in = 0; pin_in = 0; gclr = 0; goe = '0; rst_n = 1'b0;
    c.out_reg = 1'b1;
    #3;
    chk("R9 reset state", pin_out, 1'b0);
    @(negedge gclk); rst_n = 1'b1;

    // R1 R2: sweep sum and polarity
    c.out_reg = 1'b0;
    foreach (c.sum_mask[i]) c.sum_mask[i] = 1'b0;
    for (int mi = 0; mi < 4; mi++) begin
      logic [4:0] msk;
      msk = (mi == 0) ? 5'h1F : (mi == 1) ? 5'h0A : (mi == 2) ? 5'h00 : 5'h11;
      c.sum_mask = msk;
      for (int ce = 0; ce < 2; ce++)
        for (int ci = 0; ci < 2; ci++)
          for (int p = 0; p < 32; p++)
            for (int xs = 0; xs < 3; xs++) begin
              logic s, xo;
              c.casc_en = ce[0]; casc_in = ci[0]; pt = p[4:0];
              c.xor_sel = mc_xsel_e'(xs); c.xor_pt = 3'd2;
              #1;
              s  = (|(p[4:0] & msk)) | (ce[0] & ci[0]);
              xo = s ^ ((xs == 1) ? 1'b1 : (xs == 2) ? p[2] : 1'b0);
              chk("R1 cascade sum", casc_out, s);
              chk("R2 xor polarity", pin_out, xo);
            end
    end
    c.casc_en = 0; casc_in = 0;

    // R11: output enable select
    for (int os = 0; os < 5; os++)
      for (int g = 0; g < 4; g++)
        for (int pb = 0; pb < 2; pb++) begin
          c.oe_sel = mc_oesel_e'(os); c.oe_pt = 3'd3; goe = g[1:0];
          pt = pb[0] ? 5'b01000 : 5'b00000;
          #1;
          em = (os == 0) ? 1'b1 : (os == 1) ? 1'b0 : (os == 2) ? g[0] :
               (os == 3) ? g[1] : pb[0];
          chk("R11 output enable", pin_oe, em);
        end

    // R3 R10: buried register with combinatorial output
    base_cfg(); do_reset();
    c.d_sel = DS_PT; c.d_pt = 3'd3; c.sum_mask = 5'b00000;
    @(negedge gclk); pt = 5'b01000;
    edge_wait();
    @(negedge gclk); pt = 5'b00000; #1;
    for (int o = 0; o < 4; o++) begin
      c.out_reg = o[0]; c.fb_reg = o[1]; #1;
      chk("R10 pin select", pin_out, o[0] ? 1'b1 : 1'b0);
      chk("R10 feedback select", fb_out, o[1] ? 1'b1 : 1'b0);
    end
    c.out_reg = 1'b1; c.d_sel = DS_PIN;
    for (int n = 0; n < 6; n++) begin
      @(negedge gclk); pin_in = n[0];
      edge_wait();
      chk("R3 pin data path", pin_out, n[0]);
    end

    // R4 R5: D, T, JK, SR sweeps; d = pt0 ^ pt1, J/S = pt2, K/R = pt3
    for (int m = 0; m < 4; m++) begin
      base_cfg(); c.out_reg = 1'b1;
      c.sum_mask = 5'b00001; c.xor_sel = XS_PT; c.xor_pt = 3'd1;
      c.d_pt = 3'd2; c.k_pt = 3'd3; c.mode = mc_mode_e'(m);
      pt = '0; do_reset(); qm = 1'b0;
      for (int n = 0; n < 40; n++) begin
        logic [4:0] p;
        p = 5'((n * 13 + 7) % 32);
        @(negedge gclk); pt = p;
        dm = p[0] ^ p[1]; jm = p[2]; km = p[3];
        case (m)
          0: qm = dm;
          1: qm = qm ^ dm;
          2: qm = (jm & km) ? ~qm : jm ? 1'b1 : km ? 1'b0 : qm;
          default: begin sm = jm; qm = (sm & ~km) ? 1'b1 : (km & ~sm) ? 1'b0 : qm; end
        endcase
        edge_wait();
        chk((m < 2) ? "R4 D/T register" : "R5 JK/SR register", pin_out, qm);
      end
    end

    // R8: clock enable from pt4, data from pin
    base_cfg(); c.out_reg = 1'b1; c.d_sel = DS_PIN; c.ce_en = 1'b1;
    pt = '0; pin_in = 0; do_reset(); qm = 1'b0;
    for (int n = 0; n < 16; n++) begin
      @(negedge gclk); pin_in = n[0] ^ n[2]; pt = n[1] ? 5'b10000 : 5'b00000;
      if (n[1]) qm = pin_in;
      edge_wait();
      chk("R8 clock enable", pin_out, qm);
    end

    // R7 R8: product-term clock on pt2; ce (pt4 low) has no effect
    @(negedge gclk); c.clk_pt_en = 1'b1; c.clk_pt = 3'd2; pt = 5'b00000;
    pin_in = ~qm; om = qm;
    edge_wait(); edge_wait();
    chk("R7 global clock ignored", pin_out, om);
    @(negedge gclk); pt = 5'b00100; #1;
    chk("R7 R8 product-term clock edge", pin_out, ~om);
    pin_in = om; #2; pt = 5'b00000; #2;
    chk("R7 falling pt clock holds", pin_out, ~om);

    // R6: latch on global clock
    base_cfg(); c.out_reg = 1'b1; c.d_sel = DS_PIN; c.mode = MD_LATCH;
    pt = '0; do_reset();
    for (int n = 0; n < 6; n++) begin
      @(negedge gclk); pin_in = n[0] ^ n[1];
      edge_wait();
      chk("R6 latch transparent", pin_out, pin_in);
      @(negedge gclk); #1; pin_in = ~pin_in; #2;
      chk("R6 latch holds", pin_out, ~pin_in);
    end

    // R9: async clear/set sources and priority (all within the low phase)
    base_cfg(); c.out_reg = 1'b1; c.d_sel = DS_PIN;
    c.ar_sel = AR_PT; c.ar_pt = 3'd0; c.ap_en = 1'b1; c.ap_pt = 3'd1;
    pt = '0; pin_in = 0; do_reset();
    @(negedge gclk); #1;
    pt = 5'b00010; #1; chk("R9 preset", pin_out, 1'b1);
    pt = 5'b00011; #1; chk("R9 clear over preset", pin_out, 1'b0);
    pt = 5'b00010; #1; chk("R9 preset after clear", pin_out, 1'b1);
    gclr = 1; #1; chk("R9 gclr ignored in pt mode", pin_out, 1'b1);
    gclr = 0; pt = '0; #1;
    c.ar_sel = AR_OFF; pt = 5'b00001; gclr = 1; #1;
    chk("R9 clear off", pin_out, 1'b1);
    gclr = 0; pt = '0;
    c.ar_sel = AR_GLB; #1; gclr = 1; #1;
    chk("R9 global clear", pin_out, 1'b0);
    gclr = 0;
    @(negedge gclk); #1;
    pt = 5'b00010; #1; pt = 5'b00000;
    c.ar_sel = AR_BOTH; #1; pt = 5'b00001; #1;
    chk("R9 both: pt clear", pin_out, 1'b0);
    pt = 5'b00010; #1; pt = 5'b00000; gclr = 1; #1;
    chk("R9 both: global clear", pin_out, 1'b0);
    gclr = 0; #1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule